// File: doc/BRIEF.md
# Half-Duplex Line Direction Controller

This block drives the direction-enable pin of an external RS-485 transceiver on a half-duplex serial link. It tracks the transmitter's activity through three events: a byte entering the transmitter, a stop bit finishing, and the transmit queue being empty. From these it decides whether the link should be driving the bus or listening to it.

When a byte is loaded, the line turns to drive. The line turns back to listen only when the final stop bit of the last queued character has been shifted out. Between back-to-back characters the line keeps driving. The active level of the pin is selectable.

When automatic control is switched off, the pin copies a software request-to-send level. Automatic control is off after reset.

Top module: `rs485_dir_ctl`

## Requirements
- R1: While reset is asserted, and on the first clock after it, `dir_out` is 1 and the internal direction state is listen.
- R2: With `auto_en` = 0, `dir_out` equals the value `sw_rts` had at the previous rising clock edge. Transmitter events do not change `dir_out`.
- R3: With `auto_en` = 1 and `pol_inv` = 0, `dir_out` is 1 in the listen state and 0 in the drive state.
- R4: When `tx_load` = 1 at a rising edge, the state is drive after that edge, and `dir_out` shows it from that same edge.
- R5: When `tx_stop_done` = 1 and `txq_empty` = 1 at an edge with `tx_load` = 0, the state becomes listen at that edge.
- R6: A `tx_stop_done` pulse with `txq_empty` = 0 leaves the drive state unchanged, so the line does not turn around between characters.
- R7: When `tx_load`, `tx_stop_done` and `txq_empty` are all 1 at the same edge, the state is drive after that edge.
- R8: With `pol_inv` = 1, the levels of R3 are swapped: listen gives 0 and drive gives 1.
- R9: The direction state follows transmitter events even while `auto_en` = 0. Setting `auto_en` shows the state that was tracked.
- R10: `dir_out` is a register output and changes only at a rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| auto_en | input | 1 | Enables automatic direction control |
| pol_inv | input | 1 | Inverts the pin level in automatic mode |
| sw_rts | input | 1 | Software pin level used when automatic control is off |
| tx_load | input | 1 | One-cycle pulse: a byte entered the transmitter |
| tx_stop_done | input | 1 | One-cycle pulse: a stop bit finished shifting out |
| txq_empty | input | 1 | Transmit queue holds no further bytes |
| dir_out | output | 1 | Registered transceiver direction pin |

## Verification
The automatic path is exercised with four patterns:
- A single character: load, then a final stop bit.
- A train: stop bits that arrive while the queue is not empty.
- A collision: a load on the same edge as the final stop bit.
- The same sequences with the polarity inverted.

A single character separates the drive and listen levels. The train shows whether the line turns around too early. The collision shows which of two simultaneous events has priority.

Manual mode is tried by toggling the software level and pulsing transmitter events; only the software level may reach the pin. Switching to automatic mode after a load, while still disabled, shows whether the state was tracked in the background.

// File: rtl/rs485_dir_ctl.sv
module rs485_dir_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic auto_en,
  input  logic pol_inv,
  input  logic sw_rts,
  input  logic tx_load,
  input  logic tx_stop_done,
  input  logic txq_empty,
  output logic dir_out
);

  logic drive_q, drive_d, last_stop, pin_d;

  assign last_stop = tx_stop_done & txq_empty;
  assign drive_d   = tx_load ? 1'b1 : (last_stop ? 1'b0 : drive_q);
  assign pin_d     = auto_en ? (~drive_d ^ pol_inv) : sw_rts;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_q <= 1'b0;
      dir_out <= 1'b1;
    end else begin
      drive_q <= drive_d;
      dir_out <= pin_d;
    end
  end

  AST_RESET_LEVEL: assert property (@(posedge clk) !rst_n |=> dir_out && !drive_q); // R1
  AST_MANUAL_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en |=> dir_out == $past(sw_rts)); // R2
  AST_LOAD_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    auto_en && tx_load |=> dir_out == $past(pol_inv)); // R4
  AST_FINAL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    auto_en && tx_stop_done && txq_empty && !tx_load |=> dir_out == !$past(pol_inv)); // R5
  AST_NO_EARLY_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_load && !(tx_stop_done && txq_empty) |=> $stable(drive_q)); // R6
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load && tx_stop_done && txq_empty |=> drive_q); // R7

endmodule

// File: tb/test_rs485_dir_ctl.sv
module test_rs485_dir_ctl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic auto_en = 1'b0, pol_inv = 1'b0, sw_rts = 1'b1;
  logic tx_load = 1'b0, tx_stop_done = 1'b0, txq_empty = 1'b1;
  logic dir_out;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rs485_dir_ctl i_rs485_dir_ctl (
    .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .pol_inv(pol_inv),
    .sw_rts(sw_rts), .tx_load(tx_load), .tx_stop_done(tx_stop_done),
    .txq_empty(txq_empty), .dir_out(dir_out)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    tx_load = 1'b0;
    tx_stop_done = 1'b0;
  endtask

  task automatic chk(string req, logic exp);
    n_chk++;
    if (dir_out !== exp) begin
      n_bad++;
      $display("FAIL %s: dir_out=%b expected=%b", req, dir_out, exp);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 during reset", 1'b1);
    rst_n = 1'b1;
    step();
    chk("R1 after release", 1'b1);
  endtask

  task automatic t_manual();
    auto_en = 1'b0;
    sw_rts = 1'b0;
    step();
    chk("R2 sw low", 1'b0);
    tx_load = 1'b1;
    step();
    chk("R2 load ignored", 1'b0);
    sw_rts = 1'b1;
    tx_stop_done = 1'b1;
    txq_empty = 1'b1;
    step();
    chk("R2 sw high", 1'b1);
  endtask

  task automatic t_single();
    auto_en = 1'b1;
    pol_inv = 1'b0;
    step();
    chk("R3 listen high", 1'b1);
    txq_empty = 1'b1;
    tx_load = 1'b1;
    step();
    chk("R4 load drives, R3 low", 1'b0);
    step();
    step();
    chk("R4 drive held", 1'b0);
    tx_stop_done = 1'b1;
    step();
    chk("R5 final stop releases", 1'b1);
  endtask

  task automatic t_train();
    tx_load = 1'b1;
    txq_empty = 1'b0;
    step();
    chk("R4 train start", 1'b0);
    tx_stop_done = 1'b1;
    step();
    chk("R6 mid-train stop holds", 1'b0);
    tx_stop_done = 1'b1;
    step();
    chk("R6 second stop holds", 1'b0);
    txq_empty = 1'b1;
    tx_stop_done = 1'b1;
    step();
    chk("R5 train end releases", 1'b1);
  endtask

  task automatic t_collide();
    tx_load = 1'b1;
    step();
    tx_load = 1'b1;
    tx_stop_done = 1'b1;
    txq_empty = 1'b1;
    step();
    chk("R7 load wins", 1'b0);
    tx_stop_done = 1'b1;
    step();
    chk("R7 later release", 1'b1);
  endtask

  task automatic t_invert();
    pol_inv = 1'b1;
    step();
    chk("R8 listen inverted", 1'b0);
    tx_load = 1'b1;
    step();
    chk("R8 drive inverted", 1'b1);
    tx_stop_done = 1'b1;
    step();
    chk("R8 release inverted", 1'b0);
    pol_inv = 1'b0;
    step();
  endtask

  task automatic t_tracked();
    auto_en = 1'b0;
    sw_rts = 1'b1;
    tx_load = 1'b1;
    step();
    chk("R9 disabled shows sw", 1'b1);
    auto_en = 1'b1;
    step();
    chk("R9 tracked drive shown", 1'b0);
    tx_stop_done = 1'b1;
    txq_empty = 1'b1;
    step();
    chk("R9 tracked release", 1'b1);
  endtask

  task automatic t_registered();
    tx_load = 1'b1;
    #1;
    chk("R10 no change before edge", 1'b1);
    step();
    chk("R10 change after edge", 1'b0);
    tx_stop_done = 1'b1;
    step();
  endtask

  initial begin
    t_reset();
    t_manual();
    t_single();
    t_train();
    t_collide();
    t_invert();
    t_tracked();
    t_registered();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule